// File: doc/BRIEF.md
# Time-of-Day Counter with BCD and Binary Encoding

This block keeps the time of day in three byte-wide registers (seconds, minutes, hours) and moves them forward by one second each time an external update tick arrives. A control register chooses between BCD and plain binary encoding, and between 24-hour and 12-hour formats. In 12-hour format the top bit of the hours register flags PM. The hour runs 12, 1, 2 … 11, with no zero hour, and the same rules apply in both encodings.

Software loads and reads the registers through a select-based write port and a combinational read port. An upstream decoder turns the index/data bus accesses into these selects. A hold bit in the control register stops counting while software loads a consistent time. When the time wraps to midnight, the block sends a one-clock day-rollover pulse to an external calendar.

Top module: `tod_counter`

## Requirements
- R1: After reset, seconds, minutes and hours read 0x00, and the control register reads 0x04 (24-hour, BCD, counting enabled).
- R2: Select codes are 0 for seconds, 1 for minutes, 2 for hours and 3 for control. A write stores wr_data_i into the selected register, and rd_data_o returns the register chosen by rd_sel_i in the same cycle. Control occupies bits [2:0]: bit 0 is hold, bit 1 is binary encoding, bit 2 is 24-hour format. Its upper bits read as zero.
- R3: With control bit 1 at 0, all time registers count in BCD. The low nibble goes from 9 to 0 and carries into the high nibble, so 09:59:59 becomes 10:00:00. Seconds at 59 wrap to 0 and carry into minutes, and minutes at 59 carry into hours.
- R4: With control bit 1 at 1, all time registers count in plain binary, using the same wrap points as in BCD.
- R5: In 24-hour format, 23:59:59 is followed by 00:00:00.
- R6: In 12-hour format, bit 7 of the hours register is the PM flag and bits [6:0] hold 1 to 12. 11 AM goes to 12 PM. 12 PM goes to 1 PM. 11 PM goes to 12 AM. 12 AM goes to 1 AM. In BCD, 12 PM is 0x92; in binary it is 0x8C.
- R7: While the hold bit is 1, ticks leave the time registers unchanged and writes are stored as written. After hold is cleared, the next tick advances from the written values.
- R8: When any register write occurs in the same cycle as a tick, the write is stored and that tick is discarded.
- R9: day_roll_o is high for exactly the one clock after the edge at which a tick carries the time to midnight, and it is low at all other times.
- R10: If there is no tick and no write, the registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second update strobe, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for writes |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Register select for reads |
| rd_data_o | output | 8 | Read data for rd_sel_i |
| day_roll_o | output | 1 | Pulse at midnight rollover |

## Verification
The bench builds the block with its default parameters: 8-bit registers and wrap limits of 59 for seconds and minutes. At these values, every BCD nibble carry, the 12-hour PM and 12/1 transitions and the midnight wrap can be reached within a few ticks by first writing a time just before each boundary. Because ticks can be issued on every clock, a full hour of counting into midnight and a long random run with interleaved writes also fit in the run. Together these cover minute and hour carries across many different starting times.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic [1:0] {
    SEL_SEC  = 2'd0,
    SEL_MIN  = 2'd1,
    SEL_HOUR = 2'd2,
    SEL_CTRL = 2'd3
  } tod_sel_e;

  typedef struct packed {
    logic h24;
    logic bin;
    logic hold;
  } tod_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tod_ctrl_t);
endpackage

// File: rtl/tod_field_inc.sv
module tod_field_inc #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LIMIT  = 59
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic              bin_i,
  output logic [DATA_W-1:0] next_o,
  output logic              wrap_o
);
  localparam logic [DATA_W-1:0] LIM_BIN = DATA_W'(LIMIT);
  localparam logic [DATA_W-1:0] LIM_BCD = DATA_W'((LIMIT / 10) * 16 + (LIMIT % 10));

  logic [3:0]        lo;
  logic [DATA_W-5:0] hi;

  assign lo = val_i[3:0];
  assign hi = val_i[DATA_W-1:4];

  always_comb begin
    wrap_o = bin_i ? (val_i == LIM_BIN) : (val_i == LIM_BCD);
    if (wrap_o)          next_o = '0;
    else if (bin_i)      next_o = val_i + 1'b1;
    else if (lo >= 4'd9) next_o = {hi + 1'b1, 4'h0};
    else                 next_o = {hi, lo + 4'd1};
  end
endmodule

// File: rtl/tod_hour_inc.sv
module tod_hour_inc #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] hour_i,
  input  logic              bin_i,
  input  logic              h24_i,
  output logic [DATA_W-1:0] next_o,
  output logic              day_o
);
  logic [DATA_W-1:0] inc_in, inc_next;
  logic              inc_wrap;
  logic [DATA_W-2:0] h_lo, code_12, code_11;
  logic              pm;

  assign pm      = hour_i[DATA_W-1];
  assign h_lo    = hour_i[DATA_W-2:0];
  assign code_12 = bin_i ? (DATA_W-1)'(12) : (DATA_W-1)'(18);
  assign code_11 = bin_i ? (DATA_W-1)'(11) : (DATA_W-1)'(17);
  assign inc_in  = h24_i ? hour_i : {1'b0, h_lo};

  tod_field_inc #(.DATA_W(DATA_W), .LIMIT(23)) u_inc (
    .val_i (inc_in),
    .bin_i (bin_i),
    .next_o(inc_next),
    .wrap_o(inc_wrap)
  );

  always_comb begin
    next_o = inc_next;
    day_o  = 1'b0;
    if (h24_i) begin
      day_o = inc_wrap;
    end else if (h_lo == code_12) begin
      next_o = {pm, (DATA_W-1)'(1)};
    end else if (h_lo == code_11) begin
      next_o = {~pm, code_12};
      day_o  = pm;
    end else begin
      next_o = {pm, inc_next[DATA_W-2:0]};
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SEC_LAST = 59,
  parameter int unsigned MIN_LAST = 59
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              day_roll_o
);
  localparam int unsigned NFIELD = 2;

  tod_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] sec_q, min_q, hour_q;
  logic [DATA_W-1:0] fld_val [NFIELD];
  logic [DATA_W-1:0] fld_nxt [NFIELD];
  logic [NFIELD-1:0] fld_wrap;
  logic [DATA_W-1:0] hour_nxt;
  logic              hour_day, advance, carry_s, carry_m, roll_q;

  assign fld_val[0] = sec_q;
  assign fld_val[1] = min_q;

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    tod_field_inc #(
      .DATA_W(DATA_W),
      .LIMIT (i == 0 ? SEC_LAST : MIN_LAST)
    ) u_fld (
      .val_i (fld_val[i]),
      .bin_i (ctrl_q.bin),
      .next_o(fld_nxt[i]),
      .wrap_o(fld_wrap[i])
    );
  end

  tod_hour_inc #(.DATA_W(DATA_W)) u_hour (
    .hour_i(hour_q),
    .bin_i (ctrl_q.bin),
    .h24_i (ctrl_q.h24),
    .next_o(hour_nxt),
    .day_o (hour_day)
  );

  // any write in the cycle discards the tick
  assign advance = tick_i && !ctrl_q.hold && !wr_en_i;
  assign carry_s = fld_wrap[0];
  assign carry_m = carry_s && fld_wrap[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
      ctrl_q <= '{h24: 1'b1, bin: 1'b0, hold: 1'b0};
      roll_q <= 1'b0;
    end else begin
      roll_q <= advance && carry_m && hour_day;
      if (wr_en_i) begin
        unique case (tod_sel_e'(wr_sel_i))
          SEL_SEC:  sec_q  <= wr_data_i;
          SEL_MIN:  min_q  <= wr_data_i;
          SEL_HOUR: hour_q <= wr_data_i;
          SEL_CTRL: ctrl_q <= tod_ctrl_t'(wr_data_i[CTRL_W-1:0]);
          default:  ;
        endcase
      end else if (advance) begin
        sec_q <= fld_nxt[0];
        if (carry_s) min_q  <= fld_nxt[1];
        if (carry_m) hour_q <= hour_nxt;
      end
    end
  end

  always_comb begin
    unique case (tod_sel_e'(rd_sel_i))
      SEL_SEC:  rd_data_o = sec_q;
      SEL_MIN:  rd_data_o = min_q;
      SEL_HOUR: rd_data_o = hour_q;
      SEL_CTRL: rd_data_o = DATA_W'(ctrl_q);
      default:  rd_data_o = '0;
    endcase
  end

  assign day_roll_o = roll_q;

  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.hold && !wr_en_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q))); // R7

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q))); // R10

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd0) |=> (sec_q == $past(wr_data_i))); // R8

  AST_ROLL_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_roll_o |=> !day_roll_o); // R9

  AST_ROLL_AT_MIDNIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_roll_o |-> (sec_q == '0 && min_q == '0 &&
                    hour_q == (ctrl_q.h24 ? DATA_W'(0) : (ctrl_q.bin ? DATA_W'(12) : DATA_W'(18))))); // R9
endmodule

// File: tb/tod_counter_bench.sv
`timescale 1ns/100ps
module tod_counter_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0, rd_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       day_roll_o;

  int vectors = 0, miscompares = 0;
  logic [7:0] m_sec = 0, m_min = 0, m_hour = 0;
  logic [2:0] m_ctrl = 3'b100;
  bit         m_roll = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  tod_counter u_tod_counter (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .day_roll_o(day_roll_o));

  function automatic int dec(logic [7:0] b, bit bin);
    return bin ? int'(b) : int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] enc(int v, bit bin);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic model_tick();
    bit bin = m_ctrl[1], h24 = m_ctrl[2];
    int ss = dec(m_sec, bin), mm = dec(m_min, bin), hh, t, h12;
    if (h24) hh = dec(m_hour, bin);
    else hh = (dec({1'b0, m_hour[6:0]}, bin) % 12) + (m_hour[7] ? 12 : 0);
    t = hh * 3600 + mm * 60 + ss + 1;
    m_roll = (t == 86400);
    t = t % 86400;
    hh = t / 3600; mm = (t / 60) % 60; ss = t % 60;
    m_sec = enc(ss, bin); m_min = enc(mm, bin);
    if (h24) m_hour = enc(hh, bin);
    else begin
      h12 = (hh % 12 == 0) ? 12 : hh % 12;
      m_hour = {(hh >= 12) ? 1'b1 : 1'b0, 7'(enc(h12, bin))};
    end
  endtask

  task automatic cmp(logic [7:0] act, logic [7:0] exp, string tag, string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    for (int s = 0; s < 4; s++) begin
      rd_sel_i = 2'(s);
      #0.4;
      case (s)
        0: cmp(rd_data_o, m_sec, tag, "sec");
        1: cmp(rd_data_o, m_min, tag, "min");
        2: cmp(rd_data_o, m_hour, tag, "hour");
        default: cmp(rd_data_o, {5'b0, m_ctrl}, tag, "ctrl");
      endcase
    end
    cmp({7'b0, day_roll_o}, {7'b0, m_roll}, tag, "day_roll");
  endtask

  task automatic step(bit tk, bit we, int sel, int d, string tag);
    @(negedge clk);
    tick_i = tk; wr_en_i = we; wr_sel_i = 2'(sel); wr_data_i = 8'(d);
    @(posedge clk);
    m_roll = 0;
    if (we) begin
      case (sel)
        0: m_sec = 8'(d);
        1: m_min = 8'(d);
        2: m_hour = 8'(d);
        default: m_ctrl = 3'(d);
      endcase
    end else if (tk && !m_ctrl[0]) model_tick();
    #0.4;
    tick_i = 0; wr_en_i = 0;
    compare_all(tag);
  endtask

  task automatic set_time(int h, int m, int s, string tag);
    step(0, 1, 2, h, tag);
    step(0, 1, 1, m, tag);
    step(0, 1, 0, s, tag);
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    #0.4;
    compare_all("R1");

    set_time(8'h02, 8'h04, 8'h58, "R2");
    ticks(3, "R3");
    set_time(8'h09, 8'h59, 8'h59, "R3"); ticks(1, "R3");
    set_time(8'h09, 8'h59, 8'h00, "R3"); ticks(60, "R3");
    set_time(8'h23, 8'h59, 8'h59, "R5"); ticks(1, "R5_R9"); ticks(2, "R9");

    step(0, 1, 3, 3'b110, "R2");
    set_time(9, 59, 59, "R4"); ticks(1, "R4");
    set_time(23, 59, 58, "R4"); ticks(3, "R4_R9");

    step(0, 1, 3, 3'b000, "R2");
    set_time(8'h11, 8'h59, 8'h59, "R6"); ticks(1, "R6");
    set_time(8'h92, 8'h59, 8'h59, "R6"); ticks(1, "R6");
    set_time(8'h91, 8'h59, 8'h59, "R6"); ticks(2, "R6_R9");
    set_time(8'h12, 8'h59, 8'h59, "R6"); ticks(1, "R6");
    set_time(8'h81, 8'h59, 8'h00, "R6"); ticks(60, "R6");

    step(0, 1, 3, 3'b010, "R2");
    set_time(8'h8B, 59, 59, "R6"); ticks(1, "R6_R9");
    set_time(8'h8C, 59, 59, "R6"); ticks(1, "R6");
    set_time(8'h0B, 59, 59, "R6"); ticks(1, "R6");
    set_time(8'h0C, 59, 59, "R6"); ticks(1, "R6");

    step(0, 1, 3, 3'b101, "R7");
    set_time(8'h02, 8'h04, 8'h58, "R7");
    ticks(5, "R7");
    step(0, 1, 3, 3'b100, "R7");
    ticks(2, "R7");

    step(1, 1, 0, 8'h30, "R8");
    step(1, 1, 2, 8'h15, "R8");
    ticks(1, "R8");

    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, "R10");

    set_time(8'h23, 8'h00, 8'h00, "R9"); ticks(3601, "R9");

    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 3) step($urandom_range(0, 1) == 1, 1, 0, enc($urandom_range(0, 59), 0), "R3");
      else if (r < 5) step(1, 1, 1, enc($urandom_range(0, 59), 0), "R3");
      else if (r < 6) step(0, 1, 2, enc($urandom_range(0, 23), 0), "R3");
      else if (r < 20) step(0, 0, 0, 0, "R10");
      else step(1, 0, 0, 0, "R3");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule